// File: doc/BRIEF.md
# Power-of-Two Tap Cascaded Filter

This block is a multiplier-free digital filter. A serial transversal section sums `NTAPS` weighted past samples, one tap per clock, through a single shared adder. Its result then passes through a second-order recursive section. Every weight in both sections is either zero or a signed power of two, so each product reduces to an arithmetic shift and an optional negation. Used together, the two sections let a short difference sequence in the transversal taps produce a long impulse response: with an integrating feedback, the taps describe the differences of the response rather than the response itself.

Samples arrive on a strobe and are written into a circular store that keeps the last `NTAPS` inputs. Each accepted strobe starts one pass of `NTAPS` cycles. The recursive update follows one cycle later and raises a single-cycle valid pulse. The clock must therefore run at least `NTAPS + 2` times faster than the sample rate. Coefficients are written one at a time through an address/data port, and a write is only accepted when no pass is running.

Top module: `pow2_cascade_filter`

## Requirements
- R1: After reset, `y_o` is 0 and `valid_o` is 0, every coefficient is zero and the sample history and the recursive state hold zero, so the first output is 0.
- R2: A coefficient code is `QW` bits wide. Bit `QW-1` is the sign (1 = negative) and bits `QW-2:0` form a field F. F = 0 or F > KMAX+1 gives a zero coefficient; otherwise the coefficient is ±2^(F-1).
- R3: For each accepted sample x(n), taken as two's complement, the transversal result is u(n) = sum over j = 0..NTAPS-1 of d_j·x(n-j), where tap j sits at coefficient address j.
- R4: A strobe is accepted only when no pass or recursive step is in progress. A strobe at any other time is ignored: the sample is not stored and no extra output appears.
- R5: `valid_o` is high for exactly one cycle, NTAPS+1 clock edges after the edge that accepted the sample. `y_o` changes only in that cycle.
- R6: The output obeys y(n) = u(n) + c0·y(n-1) + c1·y(n-2), taken modulo 2^YW as two's complement. c0 is at address NTAPS and c1 at address NTAPS+1, and both use the R2 code.
- R7: A coefficient write takes effect only while the block is idle and only for addresses 0..NTAPS+1. A write during a pass, or to a higher address, changes no coefficient.
- R8: The transversal accumulator never overflows, including at full-scale inputs with every tap at ±2^KMAX.
- R9: The store keeps exactly the last NTAPS accepted samples, so a sample stops contributing after NTAPS further samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, at least NTAPS+2 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe |
| x_i | input | XW | Input sample, two's complement |
| cfg_we_i | input | 1 | Coefficient write enable |
| cfg_addr_i | input | CAW | Coefficient address: taps, then c0, then c1 |
| cfg_data_i | input | QW | Coefficient code |
| y_o | output | YW | Filter output, two's complement |
| valid_o | output | 1 | One-cycle pulse when a new output is presented |

## Verification
The assertions check on every cycle that the valid pulse lasts one cycle and comes exactly NTAPS+1 edges after an accepted strobe. They also check that the output holds between pulses, that an accepted strobe starts a pass, that coefficients stay frozen while a pass runs, and that the accumulator stays inside its proven magnitude bound. Only the bench scenarios can show the arithmetic itself. These cover the code decoding, including reserved magnitude fields, the windowed sum over the circular store, and the recursive update with its modulo wrap. They also show that a stray strobe or coefficient write during a pass leaves every later result unchanged.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_TAPS, ST_REC} seq_state_e;

  // shift amount field limits KMAX to 31
  typedef struct packed {
    logic       en;
    logic       neg;
    logic [4:0] sh;
  } route_t;

  function automatic route_t route_decode(input logic [15:0] code,
                                          input int unsigned qw,
                                          input int unsigned kmax);
    route_t      r;
    logic [31:0] mag;
    mag   = {16'd0, code} & ((32'd1 << (qw - 1)) - 32'd1);
    r.neg = code[4'(qw - 1)];
    r.en  = (mag != 32'd0) && (mag <= kmax + 1);
    r.sh  = 5'(mag - 32'd1);
    return r;
  endfunction

endpackage

// File: rtl/pcf_sample_store.sv
module pcf_sample_store #(
  parameter int NTAPS = 8,
  parameter int XW    = 8,
  localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [XW-1:0] din_i,
  input  logic [IW-1:0] tap_i,
  output logic [XW-1:0] dout_o
);

  logic [XW-1:0] mem_q [NTAPS];
  logic [IW-1:0] wr_q;
  logic [IW-1:0] nxt_ptr;
  logic [IW-1:0] rd_idx;

  assign nxt_ptr = (wr_q == IW'(NTAPS - 1)) ? '0 : wr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= IW'(NTAPS - 1);
      for (int i = 0; i < NTAPS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[nxt_ptr] <= din_i;
      wr_q           <= nxt_ptr;
    end
  end

  // tap j reads the sample j positions older than the newest
  always_comb begin
    if (tap_i <= wr_q) rd_idx = wr_q - tap_i;
    else               rd_idx = IW'(NTAPS) + wr_q - tap_i;
  end

  assign dout_o = mem_q[rd_idx];

endmodule

// File: rtl/pcf_coef_bank.sv
module pcf_coef_bank #(
  parameter int NTAPS = 8,
  parameter int QW    = 5,
  parameter int CAW   = 4,
  localparam int NCOEF = NTAPS + 2,
  localparam int TW    = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CAW-1:0]             addr_i,
  input  logic [QW-1:0]              data_i,
  input  logic [TW-1:0]              tap_i,
  output logic [QW-1:0]              tap_code_o,
  output logic [QW-1:0]              rc0_o,
  output logic [QW-1:0]              rc1_o,
  output logic [NCOEF-1:0][QW-1:0]   coef_o
);

  logic [NCOEF-1:0][QW-1:0] coef_q;

  for (genvar g = 0; g < NCOEF; g++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               coef_q[g] <= '0;
      else if (we_i && (addr_i == CAW'(g)))      coef_q[g] <= data_i;
    end
  end

  assign tap_code_o = coef_q[CAW'(tap_i)];
  assign rc0_o      = coef_q[NTAPS];
  assign rc1_o      = coef_q[NTAPS+1];
  assign coef_o     = coef_q;

endmodule

// File: rtl/pcf_route_shift.sv
module pcf_route_shift #(
  parameter int IW   = 8,
  parameter int OW   = 19,
  parameter int QW   = 5,
  parameter int KMAX = 7
) (
  input  logic signed [IW-1:0] din_i,
  input  logic        [QW-1:0] code_i,
  output logic signed [OW-1:0] term_o
);
  import pcf_pkg::*;

  route_t             rt;
  logic signed [OW-1:0] ext;
  logic signed [OW-1:0] shf;

  always_comb begin
    rt  = route_decode(16'(code_i), QW, KMAX);
    ext = OW'(din_i);
    shf = ext <<< rt.sh;
    if (!rt.en)      term_o = '0;
    else if (rt.neg) term_o = -shf;
    else             term_o = shf;
  end

endmodule

// File: rtl/pcf_recursive.sv
module pcf_recursive #(
  parameter int AW   = 19,
  parameter int YW   = 24,
  parameter int QW   = 5,
  parameter int KMAX = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic signed [AW-1:0] u_i,
  input  logic        [QW-1:0] c0_i,
  input  logic        [QW-1:0] c1_i,
  output logic signed [YW-1:0] y_o
);

  logic signed [YW-1:0] y1_q, y2_q;
  logic signed [YW-1:0] t0, t1, sum;

  pcf_route_shift #(.IW(YW), .OW(YW), .QW(QW), .KMAX(KMAX)) u_fb0 (
    .din_i(y1_q), .code_i(c0_i), .term_o(t0)
  );
  pcf_route_shift #(.IW(YW), .OW(YW), .QW(QW), .KMAX(KMAX)) u_fb1 (
    .din_i(y2_q), .code_i(c1_i), .term_o(t1)
  );

  // modulo 2^YW wrap is intended
  assign sum = YW'(u_i) + t0 + t1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q <= '0;
      y2_q <= '0;
    end else if (step_i) begin
      y1_q <= sum;
      y2_q <= y1_q;
    end
  end

  assign y_o = y1_q;

endmodule

// File: rtl/pow2_cascade_filter.sv
module pow2_cascade_filter #(
  parameter int NTAPS = 8,
  parameter int XW    = 8,
  parameter int KMAX  = 7,
  parameter int YW    = 24,
  localparam int QW   = $clog2(2 * (KMAX + 1) + 1),
  localparam int CAW  = $clog2(NTAPS + 2)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sample_i,
  input  logic [XW-1:0]  x_i,
  input  logic           cfg_we_i,
  input  logic [CAW-1:0] cfg_addr_i,
  input  logic [QW-1:0]  cfg_data_i,
  output logic [YW-1:0]  y_o,
  output logic           valid_o
);
  import pcf_pkg::*;

  localparam int TW    = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam int AW    = XW + KMAX + $clog2(NTAPS) + 1;
  localparam int NCOEF = NTAPS + 2;

  seq_state_e           state_q;
  logic [TW-1:0]        tap_q;
  logic signed [AW-1:0] acc_q;
  logic                 valid_q;
  logic                 busy;
  logic                 accept;
  logic                 cfg_we;

  logic [XW-1:0]            smp;
  logic [QW-1:0]            tap_code, rc0, rc1;
  logic [NCOEF-1:0][QW-1:0] coef_w;
  logic signed [AW-1:0]     term;
  logic signed [YW-1:0]     y_w;

  assign busy   = (state_q != ST_IDLE);
  assign accept = sample_i && !busy;
  assign cfg_we = cfg_we_i && !busy;

  pcf_sample_store #(.NTAPS(NTAPS), .XW(XW)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (accept),
    .din_i (x_i),
    .tap_i (tap_q),
    .dout_o(smp)
  );

  pcf_coef_bank #(.NTAPS(NTAPS), .QW(QW), .CAW(CAW)) u_coef (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr_i),
    .data_i    (cfg_data_i),
    .tap_i     (tap_q),
    .tap_code_o(tap_code),
    .rc0_o     (rc0),
    .rc1_o     (rc1),
    .coef_o    (coef_w)
  );

  pcf_route_shift #(.IW(XW), .OW(AW), .QW(QW), .KMAX(KMAX)) u_tap (
    .din_i (smp),
    .code_i(tap_code),
    .term_o(term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (state_q == ST_REC);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_TAPS;
          tap_q   <= '0;
          acc_q   <= '0;
        end
        ST_TAPS: begin
          acc_q <= acc_q + term;
          if (tap_q == TW'(NTAPS - 1)) state_q <= ST_REC;
          else                         tap_q   <= tap_q + 1'b1;
        end
        ST_REC:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pcf_recursive #(.AW(AW), .YW(YW), .QW(QW), .KMAX(KMAX)) u_rec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(state_q == ST_REC),
    .u_i   (acc_q),
    .c0_i  (rc0),
    .c1_i  (rc1),
    .y_o   (y_w)
  );

  assign y_o     = y_w;
  assign valid_o = valid_q;

endmodule

// File: rtl/pow2_cascade_filter_chk.sv
module pow2_cascade_filter_chk #(
  parameter int NTAPS = 8,
  parameter int XW    = 8,
  parameter int KMAX  = 7,
  parameter int YW    = 24,
  parameter int QW    = 5,
  parameter int AW    = 19
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sample_i,
  input logic                       valid_o,
  input logic [YW-1:0]              y_o,
  input logic                       busy_i,
  input logic signed [AW-1:0]       acc_i,
  input logic [(NTAPS+2)*QW-1:0]    coef_i
);

  localparam int    LW  = $clog2(NTAPS + 3) + 1;
  localparam longint BND = longint'(NTAPS) << (XW - 1 + KMAX);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       lat_q <= '0;
    else if (sample_i && !busy_i)                      lat_q <= LW'(1);
    else if (lat_q != '0 && lat_q < LW'(NTAPS + 2))    lat_q <= lat_q + 1'b1;
    else                                               lat_q <= '0;
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                                              // R5
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));                                         // R5
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lat_q == LW'(NTAPS + 2)));                             // R5
  AST_VALID_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LW'(NTAPS + 2)) |-> valid_o);                             // R5
  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !busy_i) |=> busy_i);                                  // R4
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(coef_i));                                        // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(acc_i) <= BND) && (longint'(acc_i) >= -BND));             // R8

endmodule

bind pow2_cascade_filter pow2_cascade_filter_chk #(
  .NTAPS(NTAPS), .XW(XW), .KMAX(KMAX), .YW(YW), .QW(QW), .AW(AW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample_i(sample_i),
  .valid_o (valid_o),
  .y_o     (y_o),
  .busy_i  (busy),
  .acc_i   (acc_q),
  .coef_i  (coef_w)
);

// File: tb/pow2_cascade_filter_bench.sv
`timescale 1ns/1ps
module pow2_cascade_filter_bench;

  localparam int NTAPS = 8;
  localparam int XW    = 8;
  localparam int KMAX  = 7;
  localparam int YW    = 24;
  localparam int QW    = $clog2(2 * (KMAX + 1) + 1);
  localparam int CAW   = $clog2(NTAPS + 2);

  localparam int STIM [16] = '{12, -7, 127, -128, 3, 0, 55, -90,
                               1, -1, 64, -64, 100, -3, 17, -50};

  logic           clk = 1'b0;
  logic           rst_ni;
  logic           sample_i;
  logic [XW-1:0]  x_i;
  logic           cfg_we_i;
  logic [CAW-1:0] cfg_addr_i;
  logic [QW-1:0]  cfg_data_i;
  logic [YW-1:0]  y_o;
  logic           valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int     cm [NTAPS+2];
  longint hist [NTAPS];
  longint my1, my2;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  pow2_cascade_filter #(.NTAPS(NTAPS), .XW(XW), .KMAX(KMAX), .YW(YW)) u_pow2_cascade_filter (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .x_i(x_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .y_o(y_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cval(input int code);
    int f;
    longint v;
    f = code & ((1 << (QW - 1)) - 1);
    if (f == 0 || f > KMAX + 1) return 0;
    v = longint'(1) << (f - 1);
    return ((code >> (QW - 1)) & 1) ? -v : v;
  endfunction

  function automatic longint wrapy(input longint v);
    longint m;
    m = v & ((longint'(1) << YW) - 1);
    if (m >= (longint'(1) << (YW - 1))) m -= (longint'(1) << YW);
    return m;
  endfunction

  function automatic longint model_step(input int x);
    longint u, y;
    for (int j = NTAPS - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    u = 0;
    for (int j = 0; j < NTAPS; j++) u += cval(cm[j]) * hist[j];
    y = wrapy(u + cval(cm[NTAPS]) * my1 + cval(cm[NTAPS+1]) * my2);
    my2 = my1;
    my1 = y;
    return y;
  endfunction

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = CAW'(addr); cfg_data_i = QW'(data);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (addr < NTAPS + 2) cm[addr] = data;
  endtask

  // kind 0: clean; 1: stray strobes mid-pass and at recursive step; 2: stray coefficient write
  task automatic send(input int x, input int kind, input string req);
    longint exp, yprev;
    @(negedge clk);
    sample_i = 1'b1; x_i = XW'(x);
    @(negedge clk);
    sample_i = 1'b0;
    exp = model_step(x);
    yprev = longint'($signed(y_o));
    for (int c = 1; c <= NTAPS + 1; c++) begin
      if (kind == 1 && (c == 2 || c == NTAPS + 1)) begin
        sample_i = 1'b1; x_i = XW'(x + 37);
      end
      if (kind == 2 && (c == 3 || c == NTAPS + 1)) begin
        cfg_we_i = 1'b1; cfg_addr_i = '0; cfg_data_i = QW'(5'b01000);
      end
      @(negedge clk);
      sample_i = 1'b0;
      cfg_we_i = 1'b0;
      if (c == NTAPS) begin
        check(valid_o == 1'b0, "R5 early valid", longint'(valid_o), 0);
        check(longint'($signed(y_o)) == yprev, "R5 y held", longint'($signed(y_o)), yprev);
      end
      if (c == NTAPS + 1) begin
        check(valid_o == 1'b1, "R5 valid", longint'(valid_o), 1);
        check(longint'($signed(y_o)) == exp, req, longint'($signed(y_o)), exp);
      end
    end
    @(negedge clk);
    check(valid_o == 1'b0, "R5 pulse width", longint'(valid_o), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int xr;
    rst_ni = 1'b0; sample_i = 1'b0; x_i = '0;
    cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_data_i = '0;
    for (int i = 0; i < NTAPS + 2; i++) cm[i] = 0;
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    my1 = 0; my2 = 0;
    repeat (3) @(negedge clk);
    check(y_o == '0, "R1 reset y", longint'(y_o), 0);
    check(valid_o == 1'b0, "R1 reset valid", longint'(valid_o), 0);
    rst_ni = 1'b1;
    // R1: zero coefficients after reset give zero output
    send(5, 0, "R1 zero coefs");

    // R2 code set incl. reserved fields; R3 impulse; R9 drop-out after NTAPS
    cfg_write(0, 5'b00001);  // +1
    cfg_write(1, 5'b10010);  // -2
    cfg_write(2, 5'b00011);  // +4
    cfg_write(3, 5'b01111);  // F=15 reserved -> 0
    cfg_write(4, 5'b10000);  // sign, F=0 -> 0
    cfg_write(7, 5'b01000);  // +128, largest shift
    send(1, 0, "R3 impulse");
    for (int i = 0; i < NTAPS + 2; i++) send(0, 0, (i >= NTAPS - 1) ? "R9 drop-out" : "R2 impulse tail");

    // R3 table walk
    cfg_write(5, 5'b11000);  // -128
    cfg_write(6, 5'b00010);  // +2
    for (int i = 0; i < 16; i++) send(STIM[i], 0, "R3 table");

    // R6 integrator, then double integrator with wrap
    cfg_write(NTAPS, 5'b00001);
    for (int i = 0; i < 8; i++) send(STIM[i], 0, "R6 integrator");
    cfg_write(NTAPS, 5'b00010);
    cfg_write(NTAPS + 1, 5'b10001);
    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      xr = int'(lcg[23:16]) - 128;
      send(xr, 0, "R6 double integrator");
    end

    // R8 full scale
    cfg_write(NTAPS, 0);
    cfg_write(NTAPS + 1, 0);
    for (int i = 0; i < NTAPS; i++) cfg_write(i, 5'b11000);
    for (int i = 0; i < NTAPS + 1; i++) send(-128, 0, "R8 full scale");
    for (int i = 0; i < NTAPS + 1; i++) send(127, 0, "R8 full scale pos");

    // R4 stray strobes
    cfg_write(0, 5'b00001);
    cfg_write(1, 5'b00010);
    for (int i = 0; i < 6; i++) send(STIM[i+3], 1, "R4 stray strobe");
    send(9, 0, "R4 after strobes");

    // R7 stray coefficient writes, busy and out of range
    for (int i = 0; i < 4; i++) send(STIM[i+8], 2, "R7 busy write");
    cfg_write(NTAPS + 4, 5'b00001);
    for (int i = 0; i < NTAPS; i++) send(STIM[i], 0, "R7 after writes");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule